// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. It runs on the output of an external two-modulus prescaler. It counts that prescaler's output cycles and drives the prescaler's modulus-control line. With a prescaler that divides by N or N+1, the frequency at the prescaler input is divided by M*N + A in total. M sets the bulk count. A sets how many of the M prescaler cycles in each division cycle use the longer N+1 modulus.

The division cycle is M prescaler cycles long. The modulus request is held high for the first A of those cycles and low for the rest. In the last cycle, the block emits one pulse for the phase detector. The A, M and mode inputs are captured only on the edge that closes a division cycle. Software can therefore change them at any time without disturbing the cycle in progress.

The mode input selects the wide prescaler (N = 16, 16/17) or the narrow one (N = 8, 8/9). In narrow mode only the lower three bits of A take effect. The block also raises a flag while a captured A is larger than the captured M, because the M*N + A relation does not hold then.

Top module: `swallow_div`

## Requirements
- R1: With mode_n8 = 0, A <= M and M >= 1, the number of prescaler-input cycles between two successive division-cycle boundaries is M*16 + A. A boundary is the prescaler-output rising edge that ends a cycle in which div_pulse was high.
- R2: With mode_n8 = 1, N is 8 and the division is M*8 + A for A <= M. The prescaler divides by N when mod_ctl = 0 and by N+1 when mod_ctl = 1.
- R3: With mode_n8 = 1, only a_val[2:0] is used. Bit a_val[3] has no effect on the division or on mod_ctl.
- R4: Within each division cycle, mod_ctl is high during exactly the first min(A, M) prescaler-output cycles and low for the remainder.
- R5: a_val, m_val and mode_n8 are captured only at a division-cycle boundary. Changes between boundaries do not alter the cycle in progress.
- R6: div_pulse is high for exactly one prescaler-output cycle per division cycle, namely its last cycle.
- R7: When the captured A exceeds the captured M, a_err is high for that entire division cycle. mod_ctl is then high for all M cycles, giving M*(N+1). Otherwise a_err is low.
- R8: An m_val of 0 is treated as 1.
- R9: While rst_n is low, mod_ctl, div_pulse and a_err are low. The reset takes effect without waiting for a pclk edge, and its release is synchronized to pclk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_val | input | 4 | Swallow count A |
| m_val | input | 15 | Main count M |
| mode_n8 | input | 1 | 1 selects N = 8 (8/9), 0 selects N = 16 (16/17) |
| mod_ctl | output | 1 | Modulus request to prescaler, 1 = N+1 |
| div_pulse | output | 1 | One-cycle pulse in the last cycle of each division cycle |
| a_err | output | 1 | Captured A larger than captured M |

## Verification
New A, M and mode values are presented while div_pulse is high. They take effect at the following boundary. Their division length, modulus-high count and pulse width can only be read at the boundary after that, one whole division cycle later, so the bench compares its per-boundary tallies only once that second boundary has been seen. a_err is registered at the capturing edge and is read on the first falling clock edge after it. The reset outputs are read 1 ns after rst_n falls, because that path has no clock.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int unsigned SWDIV_AW = 4;
  localparam int unsigned SWDIV_MW = 15;
  localparam int unsigned SWDIV_SYNC = 2;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } swdiv_mode_e;
endpackage

// File: rtl/swdiv_rst_sync.sv
module swdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = 1'b1;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/swdiv_cfg.sv
module swdiv_cfg #(
  parameter int unsigned AW = 4,
  parameter int unsigned MW = 15
) (
  input  logic          narrow,
  input  logic [AW-1:0] a_in,
  input  logic [MW-1:0] m_in,
  output logic [AW-1:0] a_eff,
  output logic [MW-1:0] m_eff,
  output logic          a_gt_m
);
  localparam int unsigned PADW = MW - AW;

  // top bit of A dropped in narrow mode
  generate
    for (genvar i = 0; i < AW; i++) begin : g_abit
      if (i == AW - 1) begin : g_top
        assign a_eff[i] = a_in[i] & ~narrow;
      end else begin : g_low
        assign a_eff[i] = a_in[i];
      end
    end
  endgenerate

  always_comb begin
    if (m_in == '0) m_eff = MW'(1);
    else            m_eff = m_in;
  end

  assign a_gt_m = {{PADW{1'b0}}, a_eff} > m_eff;
endmodule

// File: rtl/swdiv_mcnt.sv
module swdiv_mcnt #(
  parameter int unsigned MW = 15
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic [MW-1:0] m_eff,
  output logic          ld,
  output logic          pulse
);
  logic [MW-1:0] m_cnt_q;
  logic [MW-1:0] m_cnt_d;
  logic          armed_q;
  logic          arm_en;

  // terminal count closes the division cycle and reloads
  assign ld = (m_cnt_q == '0);

  always_comb begin
    if (ld) m_cnt_d = m_eff - MW'(1);
    else    m_cnt_d = m_cnt_q - MW'(1);
  end

  assign arm_en = ~armed_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      m_cnt_q <= '0;
      armed_q <= 1'b0;
    end else begin
      m_cnt_q <= m_cnt_d;
      if (arm_en) armed_q <= 1'b1;
    end
  end

  // the post-reset load state is not a real terminal count
  assign pulse = ld & armed_q;
endmodule

// File: rtl/swdiv_acnt.sv
module swdiv_acnt #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          ld,
  input  logic [AW-1:0] a_eff,
  input  logic          a_gt_m,
  output logic          mod_ctl,
  output logic          a_err,
  output logic [AW-1:0] a_cnt
);
  logic [AW-1:0] a_cnt_q;
  logic [AW-1:0] a_cnt_d;
  logic          a_en;
  logic          err_q;

  assign a_en = ld | (a_cnt_q != '0);

  always_comb begin
    if (ld) a_cnt_d = a_eff;
    else    a_cnt_d = a_cnt_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_cnt_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (a_en) a_cnt_q <= a_cnt_d;
      if (ld)   err_q   <= a_gt_m;
    end
  end

  assign mod_ctl = (a_cnt_q != '0);
  assign a_err   = err_q;
  assign a_cnt   = a_cnt_q;

  // R4: N+1 is only requested starting right after a capture edge
  assert_mod_rise_R4: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(mod_ctl) |-> $past(ld))
    else $error("mod_ctl rose without a preceding capture");
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swdiv_pkg::*;
#(
  parameter int unsigned AW   = SWDIV_AW,
  parameter int unsigned MW   = SWDIV_MW,
  parameter int unsigned SYNC = SWDIV_SYNC
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_val,
  input  logic [MW-1:0] m_val,
  input  logic          mode_n8,
  output logic          mod_ctl,
  output logic          div_pulse,
  output logic          a_err
);
  localparam logic [AW:0] NARROW_LIM = (AW+1)'(1) << (AW - 1);

  logic          rst_q;
  logic [AW-1:0] a_eff;
  logic [MW-1:0] m_eff;
  logic          a_gt_m;
  logic          ld;
  logic [AW-1:0] a_cnt;
  swdiv_mode_e   mode_sel;

  assign mode_sel = swdiv_mode_e'(mode_n8);

  swdiv_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk   (pclk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  swdiv_cfg #(.AW(AW), .MW(MW)) u_cfg (
    .narrow (mode_sel == MODE_NARROW),
    .a_in   (a_val),
    .m_in   (m_val),
    .a_eff  (a_eff),
    .m_eff  (m_eff),
    .a_gt_m (a_gt_m)
  );

  swdiv_mcnt #(.MW(MW)) u_mcnt (
    .clk   (pclk),
    .rst_q (rst_q),
    .m_eff (m_eff),
    .ld    (ld),
    .pulse (div_pulse)
  );

  swdiv_acnt #(.AW(AW)) u_acnt (
    .clk     (pclk),
    .rst_q   (rst_q),
    .ld      (ld),
    .a_eff   (a_eff),
    .a_gt_m  (a_gt_m),
    .mod_ctl (mod_ctl),
    .a_err   (a_err),
    .a_cnt   (a_cnt)
  );

  // R6: a pulse is followed by a non-pulse cycle unless M was 1
  assert_pulse_width_R6: assert property (@(posedge pclk) disable iff (!rst_q)
    div_pulse |=> (!div_pulse || $past(m_eff) == MW'(1)))
    else $error("div_pulse wider than one cycle");

  // R7: the error flag only moves on a capture edge
  assert_err_stable_R7: assert property (@(posedge pclk) disable iff (!rst_q)
    !ld |=> $stable(a_err))
    else $error("a_err changed mid cycle");

  // R3: a narrow-mode capture never loads more than three bits of A
  assert_narrow_a_R3: assert property (@(posedge pclk) disable iff (!rst_q)
    (ld && mode_n8) |=> ({1'b0, a_cnt} < NARROW_LIM))
    else $error("narrow mode loaded a wide A");

  // R9: outputs are quiet while reset is held
  assert_reset_quiet_R9: assert property (@(posedge pclk)
    !rst_q |-> (!mod_ctl && !div_pulse && !a_err))
    else $error("outputs active in reset");
endmodule

// File: tb/swallow_div_bench.sv
module swallow_div_bench;
  logic        vclk = 1'b0;
  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  a_val = 4'd1;
  logic [14:0] m_val = 15'd4;
  logic        mode_n8 = 1'b0;
  logic        mod_ctl, div_pulse, a_err;

  int checks = 0;
  int errors = 0;

  always #5 vclk = ~vclk;

  swallow_div u_swallow_div (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .a_val     (a_val),
    .m_val     (m_val),
    .mode_n8   (mode_n8),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .a_err     (a_err)
  );

  // behavioural dual-modulus prescaler, mode latched per output cycle
  int   pcnt = 0;
  logic pmode = 1'b0;
  always @(posedge vclk) begin
    if (pcnt >= (pmode ? 8 : 16) + int'(mod_ctl) - 1) begin
      pcnt  <= 0;
      pclk  <= 1'b1;
      pmode <= mode_n8;
    end else begin
      pcnt <= pcnt + 1;
      if (pcnt == 3) pclk <= 1'b0;
    end
  end

  // boundary monitor
  int   vc = 0, bcount = 0, last_len = 0, last_mod = 0, last_pw = 0;
  int   modacc = 0, pwacc = 0;
  logic prev_pc = 1'b0, prev_ps = 1'b0;
  always @(negedge vclk) begin
    vc = vc + 1;
    if (pclk && !prev_pc) begin
      if (prev_ps) begin
        last_len = vc; last_mod = modacc; last_pw = pwacc;
        vc = 0; modacc = 0; pwacc = 0;
        bcount = bcount + 1;
      end
      modacc = modacc + int'(mod_ctl);
      pwacc  = pwacc + int'(div_pulse);
      prev_ps = div_pulse;
    end
    prev_pc = pclk;
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int eff_m(input int m);
    return (m == 0) ? 1 : m;
  endfunction
  function automatic int eff_a(input int a, input int n8);
    return n8 ? (a & 7) : a;
  endfunction
  function automatic int min2(input int x, input int y);
    return (x < y) ? x : y;
  endfunction
  function automatic int exp_ratio(input int m, input int a, input int n8);
    return eff_m(m) * (n8 ? 8 : 16) + min2(eff_a(a, n8), eff_m(m));
  endfunction

  task automatic run_case(input int m, input int a, input int n8, input int glitch, input string tag);
    int b0;
    int got_err;
    @(negedge vclk);
    while (div_pulse !== 1'b1) @(negedge vclk);
    m_val = 15'(m); a_val = 4'(a); mode_n8 = n8[0];
    b0 = bcount;
    wait (bcount == b0 + 1);
    got_err = int'(a_err);
    if (glitch != 0) begin
      repeat (3) @(negedge vclk);
      m_val = ~15'(m); a_val = ~4'(a);
      repeat (3) @(negedge vclk);
      m_val = 15'(m); a_val = 4'(a);
    end
    wait (bcount == b0 + 2);
    chk(tag, "ratio", last_len, exp_ratio(m, a, n8));
    chk("R4", "mod_high_cycles", last_mod, min2(eff_a(a, n8), eff_m(m)));
    chk("R7", "a_err", got_err, int'(eff_a(a, n8) > eff_m(m)));
    chk("R6", "pulse_cycles", last_pw, 1);
  endtask

  initial begin
    repeat (190000) @(posedge vclk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = int'($urandom(32'h5EED));
    repeat (40) @(negedge vclk);
    chk("R9", "mod_ctl_in_reset", int'(mod_ctl), 0);
    chk("R9", "div_pulse_in_reset", int'(div_pulse), 0);
    chk("R9", "a_err_in_reset", int'(a_err), 0);
    rst_n = 1'b1;

    run_case(4, 1, 0, 0, "R1");
    run_case(1, 0, 0, 0, "R1");
    run_case(1, 1, 0, 0, "R1");
    run_case(15, 15, 0, 0, "R1");
    run_case(5, 5, 1, 0, "R2");
    run_case(3, 0, 1, 0, "R2");
    run_case(3, 7, 1, 0, "R7");
    run_case(10, 12, 1, 0, "R3");
    run_case(0, 1, 0, 0, "R8");
    run_case(0, 3, 1, 0, "R8");
    run_case(6, 2, 0, 1, "R5");
    run_case(4, 9, 1, 1, "R5");

    for (int i = 0; i < 24; i++) begin
      int m, a, n8;
      m  = int'($urandom_range(1, 40));
      a  = int'($urandom_range(0, 15));
      n8 = int'($urandom_range(0, 1));
      run_case(m, a, n8, ((i % 2) == 1 && m >= 3) ? 1 : 0, "R1");
    end

    // mid-cycle reset while N+1 is requested
    run_case(20, 10, 0, 0, "R1");
    repeat (20) @(negedge vclk);
    chk("R4", "mod_ctl_early_cycle", int'(mod_ctl), 1);
    rst_n = 1'b0;
    #1;
    chk("R9", "mod_ctl_async_reset", int'(mod_ctl), 0);
    chk("R9", "div_pulse_async_reset", int'(div_pulse), 0);
    repeat (60) @(negedge vclk);
    rst_n = 1'b1;
    run_case(7, 3, 1, 0, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule